// File: doc/BRIEF.md
# Phase-Error Lock Monitor

This block decides whether a phase-locked loop is in lock. It watches two clocks that have already been divided down to the same compare rate, one from the reference path and one from the oscillator feedback path. Both are oversampled on a fast system clock and passed through synchronizers. The XOR of the two synchronized samples is the phase error. A clock pair in phase gives an XOR that stays low. A 180° offset gives an XOR that stays high. Clocks that differ in frequency give an XOR whose duty cycle sweeps through the whole range at the beat rate.

A first-order recursive filter averages the XOR duty. The filter is an accumulator that moves a 2^-k fraction of the way toward full scale or toward zero on every sample. The top byte of the accumulator is the averaged phase error on a 0 to 180° scale, and it is compared with a programmable threshold. The threshold is held in an 8-bit register in which 255 means 180°. It resets to 64, the code nearest 45°. A hysteresis band around the threshold stops the flag from chattering. The flag is high while in lock and low on loss of lock. It stays low after reset until the filter has had time to settle.

The clocks, the threshold and the settings are plain control pins with no handshake. To detect slow beats, choose k so that the filter corner sits about a decade below the smallest beat frequency of interest.

Top module: `lolmon_xor_lock`

## Requirements
- R1: `ref_div` and `vco_div` each pass through SYNC_STAGES (default 2) flops before being XORed. The XOR drives the filter on the following edge, and the flag reacts one edge after that. With k=0, a step from matched inputs to differing inputs lowers `lock_good` on the fourth rising edge after the change.
- R2: On each edge the 16-bit accumulator becomes acc + floor((T - acc) / 2^k). T is 65535 when the XOR sample is 1 and 0 when it is 0. The accumulator never falls while the XOR is 1 and never rises while it is 0.
- R3: `k_shift` (0 to 15) sets the filter time constant. A larger value makes the response to a phase step slower.
- R4: The threshold register loads `thr_in` on any edge where `thr_wr` is 1. Code 255 means 180°. The register resets to 64, which is 45°.
- R5: The filtered level is bits 15:8 of the accumulator. While in lock, the flag drops on the next edge when the level exceeds min(threshold + `hyst`, 255). It stays high while the level is at or below that limit.
- R6: While out of lock and after settling, the flag rises on the next edge when the level is below max(threshold - `hyst`, 0). It stays low while the level is at or above that limit.
- R7: After reset, `lock_good` is held low while fewer than 2^(k+3) rising edges have passed. With in-phase clocks and k=5, the flag is low after edge 256 and high after edge 257.
- R8: While `rst_n` is low, the accumulator is cleared and `lock_good` is 0.
- R9: Clocks of unequal frequency produce a beat that drives `lock_good` low.
- R10: In-phase clocks, or a small phase offset well under the threshold, leave `lock_good` high once settled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oversampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_div | input | 1 | Divided reference clock |
| vco_div | input | 1 | Divided oscillator feedback clock |
| thr_in | input | 8 | Threshold value to load, 255 = 180° |
| thr_wr | input | 1 | Loads `thr_in` into the threshold register |
| hyst | input | 4 | Half-width of the hysteresis band, in level codes |
| k_shift | input | 4 | Filter shift k |
| lock_good | output | 1 | High in lock, low on loss of lock |

## Verification
The bench aims at the settle window and checks that the flag is still low after edge 256 and high after edge 257. A counter that is off by one, or one that ignores k, would release the flag a cycle early or late. With k=0 the bench measures the latency from a changed input to the flag's fall exactly, so a missing or extra synchronizer stage shows up as a one-cycle shift. It drives the level into the band between the threshold and each hysteresis limit, on the rise and on the fall. A design without hysteresis, or with the band applied on the wrong side, would flip the flag there. It also checks that a beat between unequal clocks is caught, and that a larger k slows the response.

// File: rtl/lolmon_pkg.sv
package lolmon_pkg;

  typedef enum logic {
    ST_UNLOCK = 1'b0,
    ST_LOCK   = 1'b1
  } lock_st_e;

  // Level code nearest 45 degrees when full scale stands for 180 degrees.
  function automatic int default_thr(input int lvl_w);
    return (((1 << lvl_w) - 1) * 45 + 90) / 180;
  endfunction

endpackage

// File: rtl/lolmon_sync.sv
module lolmon_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);

  logic [STAGES-1:0] pipe_q;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) pipe_q[0] <= 1'b0;
          else        pipe_q[0] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) pipe_q[i] <= 1'b0;
          else        pipe_q[i] <= pipe_q[i-1];
        end
      end
    end
  endgenerate

  assign q = pipe_q[STAGES-1];

endmodule

// File: rtl/lolmon_iir.sv
module lolmon_iir #(
  parameter int ACC_W = 16,
  parameter int K_W   = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             x,
  input  logic [K_W-1:0]   k,
  output logic [ACC_W-1:0] acc
);

  localparam int EXT_W = ACC_W + 2;

  logic [ACC_W-1:0]        acc_q;
  logic [ACC_W-1:0]        tgt;
  logic signed [EXT_W-1:0] diff;
  logic signed [EXT_W-1:0] step;
  logic signed [EXT_W-1:0] sum;

  always_comb begin
    tgt  = x ? {ACC_W{1'b1}} : '0;
    diff = $signed({2'b00, tgt}) - $signed({2'b00, acc_q});
    step = diff >>> k;
    sum  = $signed({2'b00, acc_q}) + step;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) acc_q <= '0;
    else        acc_q <= sum[ACC_W-1:0];
  end

  assign acc = acc_q;

endmodule

// File: rtl/lolmon_decide.sv
module lolmon_decide
  import lolmon_pkg::*;
#(
  parameter int LVL_W      = 8,
  parameter int HYST_W     = 4,
  parameter int K_W        = 4,
  parameter int SETTLE_LOG = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [LVL_W-1:0]  lvl,
  input  logic [LVL_W-1:0]  thr,
  input  logic [HYST_W-1:0] hyst,
  input  logic [K_W-1:0]    k,
  output logic              lock
);

  localparam int CNT_W = (1 << K_W) - 1 + SETTLE_LOG + 1;
  localparam int SUM_W = LVL_W + 1;

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] settle_len;
  logic             settled;
  logic [SUM_W-1:0] hi_sum;
  logic [LVL_W-1:0] hyst_ext;
  logic [LVL_W-1:0] hi_lim;
  logic [LVL_W-1:0] lo_lim;
  lock_st_e         st_q, st_d;

  always_comb begin
    settle_len = {{(CNT_W-1){1'b0}}, 1'b1} << (32'(k) + SETTLE_LOG);
    settled    = (cnt_q >= settle_len);
    hyst_ext   = LVL_W'(hyst);
    hi_sum     = {1'b0, thr} + {1'b0, hyst_ext};
    hi_lim     = hi_sum[LVL_W] ? {LVL_W{1'b1}} : hi_sum[LVL_W-1:0];
    lo_lim     = (thr > hyst_ext) ? (thr - hyst_ext) : '0;
    st_d       = st_q;
    if (!settled) begin
      st_d = ST_UNLOCK;
    end else begin
      case (st_q)
        ST_LOCK:   if (lvl > hi_lim) st_d = ST_UNLOCK;
        ST_UNLOCK: if (lvl < lo_lim) st_d = ST_LOCK;
        default:   st_d = ST_UNLOCK;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      st_q  <= ST_UNLOCK;
    end else begin
      if (cnt_q != {CNT_W{1'b1}}) cnt_q <= cnt_q + 1'b1;
      st_q <= st_d;
    end
  end

  assign lock = (st_q == ST_LOCK);

endmodule

// File: rtl/lolmon_xor_lock.sv
module lolmon_xor_lock
  import lolmon_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int ACC_W       = 16,
  parameter int LVL_W       = 8,
  parameter int K_W         = 4,
  parameter int HYST_W      = 4,
  parameter int SETTLE_LOG  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ref_div,
  input  logic              vco_div,
  input  logic [LVL_W-1:0]  thr_in,
  input  logic              thr_wr,
  input  logic [HYST_W-1:0] hyst,
  input  logic [K_W-1:0]    k_shift,
  output logic              lock_good
);

  localparam logic [LVL_W-1:0] THR_RST = LVL_W'(default_thr(LVL_W));

  logic [1:0]       raw_in;
  logic [1:0]       synced;
  logic             phase_x;
  logic [ACC_W-1:0] acc_w;
  logic [LVL_W-1:0] lvl;
  logic [LVL_W-1:0] thr_q;

  assign raw_in = {vco_div, ref_div};

  generate
    for (genvar c = 0; c < 2; c++) begin : g_sync
      lolmon_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (raw_in[c]),
        .q     (synced[c])
      );
    end
  endgenerate

  assign phase_x = synced[0] ^ synced[1];

  lolmon_iir #(.ACC_W(ACC_W), .K_W(K_W)) u_iir (
    .clk   (clk),
    .rst_n (rst_n),
    .x     (phase_x),
    .k     (k_shift),
    .acc   (acc_w)
  );

  assign lvl = acc_w[ACC_W-1 -: LVL_W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      thr_q <= THR_RST;
    else if (thr_wr) thr_q <= thr_in;
  end

  lolmon_decide #(
    .LVL_W(LVL_W), .HYST_W(HYST_W), .K_W(K_W), .SETTLE_LOG(SETTLE_LOG)
  ) u_decide (
    .clk   (clk),
    .rst_n (rst_n),
    .lvl   (lvl),
    .thr   (thr_q),
    .hyst  (hyst),
    .k     (k_shift),
    .lock  (lock_good)
  );

endmodule

// File: rtl/lolmon_chk.sv
module lolmon_chk #(
  parameter int ACC_W      = 16,
  parameter int LVL_W      = 8,
  parameter int K_W        = 4,
  parameter int HYST_W     = 4,
  parameter int SETTLE_LOG = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              phase_x,
  input logic [ACC_W-1:0]  acc_q,
  input logic [LVL_W-1:0]  lvl,
  input logic [LVL_W-1:0]  thr_q,
  input logic [LVL_W-1:0]  thr_in,
  input logic              thr_wr,
  input logic [HYST_W-1:0] hyst,
  input logic [K_W-1:0]    k_shift,
  input logic              lock_good
);

  localparam int LVL_MAX = (1 << LVL_W) - 1;
  localparam int THR_DEF = (LVL_MAX * 45 + 90) / 180;

  logic [23:0] edges_q;
  int          hi_i, lo_i, settle_i;
  logic        past_settle;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                edges_q <= '0;
    else if (edges_q != '1)    edges_q <= edges_q + 1'b1;
  end

  always_comb begin
    hi_i = int'(thr_q) + int'(hyst);
    if (hi_i > LVL_MAX) hi_i = LVL_MAX;
    lo_i = int'(thr_q) - int'(hyst);
    if (lo_i < 0) lo_i = 0;
    settle_i    = 1 << (int'(k_shift) + SETTLE_LOG);
    past_settle = (int'(edges_q) >= settle_i);
  end

  // R2
  acc_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    phase_x |=> acc_q >= $past(acc_q));

  // R2
  acc_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !phase_x |=> acc_q <= $past(acc_q));

  // R4
  thr_default_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(rst_n) |-> int'(thr_q) == THR_DEF);

  // R4
  thr_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(thr_wr) && $past(rst_n)) |-> thr_q == $past(thr_in));

  // R5
  unlock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_good && int'(lvl) > hi_i) |=> !lock_good);

  // R5
  lock_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_good && past_settle && int'(lvl) <= hi_i) |=> lock_good);

  // R6
  relock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!lock_good && past_settle && int'(lvl) < lo_i) |=> lock_good);

  // R6
  unlock_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!lock_good && int'(lvl) >= lo_i) |=> !lock_good);

  // R7
  settle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !past_settle |=> !lock_good);

  // R8
  reset_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(rst_n) |-> (acc_q == '0 && !lock_good));

endmodule

bind lolmon_xor_lock lolmon_chk #(
  .ACC_W(ACC_W), .LVL_W(LVL_W), .K_W(K_W), .HYST_W(HYST_W), .SETTLE_LOG(SETTLE_LOG)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .phase_x   (phase_x),
  .acc_q     (acc_w),
  .lvl       (lvl),
  .thr_q     (thr_q),
  .thr_in    (thr_in),
  .thr_wr    (thr_wr),
  .hyst      (hyst),
  .k_shift   (k_shift),
  .lock_good (lock_good)
);

// File: tb/sim_lolmon_xor_lock.sv
module sim_lolmon_xor_lock;

  localparam int NSYNC = 2;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ref_div = 1'b0;
  logic       vco_div = 1'b0;
  logic [7:0] thr_in = 8'd0;
  logic       thr_wr = 1'b0;
  logic [3:0] hyst = 4'd4;
  logic [3:0] k_shift = 4'd5;
  logic       lock_good;

  always #10 clk = ~clk;

  lolmon_xor_lock u0 (
    .clk(clk), .rst_n(rst_n), .ref_div(ref_div), .vco_div(vco_div),
    .thr_in(thr_in), .thr_wr(thr_wr), .hyst(hyst), .k_shift(k_shift),
    .lock_good(lock_good)
  );

  int    n_run = 0;
  int    n_fail = 0;
  string tag = "R8";
  bit    done = 0;

  // Behavioural reference model, updated on each rising edge.
  int m_rs[NSYNC];
  int m_vs[NSYNC];
  int m_acc, m_cnt, m_thr, m_lock;
  int t_x, t_tgt, t_step, t_lvl, t_hi, t_lo, t_nlock;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NSYNC; i++) begin m_rs[i] = 0; m_vs[i] = 0; end
      m_acc = 0; m_cnt = 0; m_thr = 64; m_lock = 0;
    end else begin
      t_x = m_rs[NSYNC-1] ^ m_vs[NSYNC-1];
      for (int i = NSYNC-1; i > 0; i--) begin m_rs[i] = m_rs[i-1]; m_vs[i] = m_vs[i-1]; end
      m_rs[0] = int'(ref_div);
      m_vs[0] = int'(vco_div);
      t_tgt  = t_x ? 65535 : 0;
      t_step = (t_tgt - m_acc) >>> int'(k_shift);
      t_lvl  = m_acc / 256;
      t_hi   = m_thr + int'(hyst); if (t_hi > 255) t_hi = 255;
      t_lo   = m_thr - int'(hyst); if (t_lo < 0) t_lo = 0;
      if (m_cnt < (1 << (int'(k_shift) + 3))) t_nlock = 0;
      else if (m_lock != 0)                  t_nlock = (t_lvl > t_hi) ? 0 : 1;
      else                                   t_nlock = (t_lvl < t_lo) ? 1 : 0;
      m_acc  = m_acc + t_step;
      if (m_cnt < (1 << 19) - 1) m_cnt++;
      m_lock = t_nlock;
      if (thr_wr) m_thr = int'(thr_in);
    end
  end

  task automatic chk(input logic act, input int exp, input string req, input string what);
    n_run++;
    if (act !== 1'(exp)) begin
      n_fail++;
      $display("FAIL %s %s: actual %0b expected %0d at %0t", req, what, act, exp, $time);
    end
  endtask

  // Stimulus pattern: 0 = two clocks, 1 = differing static levels, 2 = both low.
  int pr = 16, pv = 16, dph = 0, pat = 2, ph = 0;

  task automatic drive();
    case (pat)
      0: begin
        ref_div = ((ph % pr) < pr / 2);
        vco_div = (((ph + dph) % pv) < pv / 2);
      end
      1: begin ref_div = 1'b1; vco_div = 1'b0; end
      default: begin ref_div = 1'b0; vco_div = 1'b0; end
    endcase
    ph++;
  endtask

  task automatic run(input int n);
    repeat (n) begin
      @(negedge clk);
      chk(lock_good, m_lock, tag, "cycle compare with model");
      drive();
    end
  endtask

  task automatic finish_up();
    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_run++;
    n_fail++;
    $display("FAIL R1..all watchdog: actual running expected finished");
    finish_up();
  end

  int  saw_low, t5, t2;
  bit  did_up, did_dn;

  initial begin
    // R8: reset holds the flag low
    repeat (4) begin
      @(negedge clk);
      chk(lock_good, 0, "R8", "flag during reset");
    end
    @(negedge clk);
    rst_n = 1'b1;
    pat = 0; dph = 0;
    drive();

    // R7: settle window with k=5 is 256 edges
    tag = "R7";
    run(256);
    chk(lock_good, 0, "R7", "still settling after edge 256");
    run(1);
    chk(lock_good, 1, "R7", "released after edge 257");
    chk(lock_good, 1, "R10", "in-phase clocks locked");

    // R10 / R5: 22.5 degree offset, default threshold of 45 degrees
    tag = "R5";
    dph = 1;
    run(300);
    chk(lock_good, 1, "R10", "22.5 deg offset stays locked");

    // R4: 90 degree offset above default 45 degree threshold
    tag = "R4";
    dph = 4;
    run(300);
    chk(lock_good, 0, "R4", "90 deg above default threshold");

    // R4: raise threshold to code 200 (about 141 degrees)
    thr_in = 8'd200; thr_wr = 1'b1;
    run(1);
    thr_wr = 1'b0;
    run(300);
    chk(lock_good, 1, "R4", "90 deg below raised threshold");

    // R9: unequal periods produce a beat
    thr_in = 8'd64; thr_wr = 1'b1;
    run(1);
    thr_wr = 1'b0;
    tag = "R9";
    dph = 0; pv = 18; saw_low = 0;
    for (int i = 0; i < 2000; i++) begin
      run(1);
      if (lock_good === 1'b0) saw_low = 1;
    end
    chk(1'(saw_low), 1, "R9", "beat seen as loss of lock");

    // R3 / R2: response time grows with k
    tag = "R2";
    pv = 16; pat = 2;
    run(150);
    chk(lock_good, 1, "R3", "locked before step, k=5");
    pat = 1; t5 = 0;
    while (lock_good === 1'b1 && t5 < 200) begin run(1); t5++; end
    pat = 2;
    run(200);
    k_shift = 4'd2;
    run(20);
    chk(lock_good, 1, "R3", "locked before step, k=2");
    pat = 1; t2 = 0;
    while (lock_good === 1'b1 && t2 < 200) begin run(1); t2++; end
    chk(1'(t2 < t5), 1, "R3", "k=2 reacts faster than k=5");

    // R5 / R6: hysteresis band of 15 around threshold 64
    tag = "R6";
    k_shift = 4'd5; hyst = 4'd15; pat = 2;
    run(300);
    chk(lock_good, 1, "R6", "relocked before hysteresis test");
    pat = 1; did_up = 0;
    for (int i = 0; i < 300; i++) begin
      run(1);
      if (!did_up && (m_acc / 256) > 64 && (m_acc / 256) <= 79) begin
        did_up = 1;
        chk(lock_good, 1, "R5", "level above threshold inside band keeps lock");
      end
    end
    chk(1'(did_up), 1, "R5", "level passed through upper band");
    chk(lock_good, 0, "R5", "level far above band unlocks");
    pat = 2; did_dn = 0;
    for (int i = 0; i < 400; i++) begin
      run(1);
      if (!did_dn && (m_acc / 256) < 64 && (m_acc / 256) >= 49) begin
        did_dn = 1;
        chk(lock_good, 0, "R6", "level below threshold inside band stays unlocked");
      end
    end
    chk(1'(did_dn), 1, "R6", "level passed through lower band");
    chk(lock_good, 1, "R6", "level below band relocks");

    // R1: synchronizer and filter latency with k=0
    tag = "R1";
    k_shift = 4'd0; hyst = 4'd4; pat = 2;
    run(20);
    chk(lock_good, 1, "R1", "locked before step");
    @(negedge clk);
    chk(lock_good, m_lock, "R1", "cycle compare with model");
    pat = 1;
    drive();
    run(3);
    chk(lock_good, 1, "R1", "flag still high after third edge");
    run(1);
    chk(lock_good, 0, "R1", "flag low after fourth edge");

    finish_up();
  end

endmodule